// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit performs one single-bit operation on a byte operand each time a request is accepted. The caller supplies the operand byte, a bit index, an operation code and the present carry and zero flags. The unit returns the possibly modified byte, a flag that says whether that byte must be written back to wherever it came from, and the updated carry and zero flags. How the operand is fetched and how it is written back stay with the caller.

The operations fall into three groups. The first group edits a bit: set, clear and invert. The second group moves a bit between the operand and carry: load a bit or its complement into carry, and store carry or its complement into a bit. The third group folds a bit, or its complement, into carry with AND, OR or XOR. Test reports an addressed bit through the zero flag. Each operation has a fixed write-back rule, and any flag that an operation does not name passes through unchanged.

Requests use a valid/ready handshake. Results leave through a registered output stage with its own valid/ready handshake. The result appears in the cycle after acceptance. A stalled output holds its contents steady.

Top module: `bit_op_unit`

## Requirements
- R1: The addressed bit is `data_i[bit_sel_i]`, with `bit_sel_i` in 0..7. No operation changes any other bit of `data_o`, which keeps the value from `data_i`.
- R2: Code 0 sets, code 1 clears and code 2 inverts the addressed bit. Each of these raises `wr_en_o` and leaves both flags unchanged.
- R3: Code 3 (test) drives `z_o` to 1 when the addressed bit is 0 and to 0 when it is 1. It keeps `wr_en_o` low, returns the byte unchanged and keeps `c_o` equal to `c_i`.
- R4: Code 4 copies the addressed bit into `c_o`. Code 5 copies its complement into `c_o`. Neither raises `wr_en_o` nor changes the byte.
- R5: Code 6 writes `c_i` into the addressed bit. Code 7 writes the complement of `c_i` into it. Both raise `wr_en_o` and keep `c_o` equal to `c_i`.
- R6: Codes 8/9 AND, codes 10/11 OR and codes 12/13 XOR `c_i` with the addressed bit (even codes) or with its complement (odd codes). The result goes to `c_o`. `wr_en_o` stays low and the byte is unchanged.
- R7: `z_o` equals `z_i` for every code except 3. `c_o` equals `c_i` for codes 0, 1, 2, 3, 6 and 7.
- R8: Codes 14 and 15 have no effect: `wr_en_o` is low and the byte and both flags are returned unchanged.
- R9: After reset `out_valid_o` is 0 and `in_ready_o` is 1. A request accepted at a clock edge shows its result with `out_valid_o` high after that same edge.
- R10: While `out_valid_o` is high and `out_ready_i` is low, the output holds its payload and `in_ready_o` is low. When the output drains, a new request is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Unit can accept a request |
| op_i | input | 4 | Operation code |
| data_i | input | DATA_W | Operand byte |
| bit_sel_i | input | IDX_W | Index of the addressed bit |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| data_o | output | DATA_W | Resulting byte |
| wr_en_o | output | 1 | Byte must be written back |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |

## Verification
The bench uses the default 8-bit operand with a 3-bit index. At that size the full cross of the sixteen codes, all eight bit positions and all four flag combinations is small enough to sweep completely. Each combination runs against four byte patterns: all zeros, all ones and two alternating patterns, so every addressed bit is seen both at 0 and at 1. A separate stall sequence holds the output not-ready so that payload retention and the same-cycle drain-and-accept can be observed at the ports.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [3:0] {
    OP_SET  = 4'd0,
    OP_CLR  = 4'd1,
    OP_INV  = 4'd2,
    OP_TST  = 4'd3,
    OP_LDC  = 4'd4,
    OP_LDCN = 4'd5,
    OP_STC  = 4'd6,
    OP_STCN = 4'd7,
    OP_AND  = 4'd8,
    OP_ANDN = 4'd9,
    OP_OR   = 4'd10,
    OP_ORN  = 4'd11,
    OP_XOR  = 4'd12,
    OP_XORN = 4'd13
  } bit_op_e;

  localparam int unsigned OP_W = 4;
endpackage

// File: rtl/bit_mask_gen.sv
module bit_mask_gen #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  sel_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign mask_o[i] = (sel_i == IDX_W'(i));
  end
endmodule

// File: rtl/bit_logic.sv
module bit_logic
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              c_i,
  input  logic              z_i,
  output logic [DATA_W-1:0] data_o,
  output logic              wr_en_o,
  output logic              c_o,
  output logic              z_o
);
  logic bit_val;
  logic opnd;   // bit value, complemented for the inverted variants
  logic c_src;

  assign bit_val = |(data_i & mask_i);
  assign opnd    = bit_val ^ op_i[0];
  assign c_src   = c_i ^ op_i[0];

  always_comb begin
    data_o  = data_i;
    wr_en_o = 1'b0;
    c_o     = c_i;
    z_o     = z_i;
    case (op_i)
      OP_SET: begin
        data_o  = data_i | mask_i;
        wr_en_o = 1'b1;
      end
      OP_CLR: begin
        data_o  = data_i & ~mask_i;
        wr_en_o = 1'b1;
      end
      OP_INV: begin
        data_o  = data_i ^ mask_i;
        wr_en_o = 1'b1;
      end
      OP_TST:           z_o = ~bit_val;
      OP_LDC, OP_LDCN:  c_o = opnd;
      OP_STC, OP_STCN: begin
        data_o  = c_src ? (data_i | mask_i) : (data_i & ~mask_i);
        wr_en_o = 1'b1;
      end
      OP_AND, OP_ANDN:  c_o = c_i & opnd;
      OP_OR,  OP_ORN:   c_o = c_i | opnd;
      OP_XOR, OP_XORN:  c_o = c_i ^ opnd;
      default: ;
    endcase
  end
endmodule

// File: rtl/bit_out_reg.sv
module bit_out_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wr_en_i,
  input  logic              c_i,
  input  logic              z_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] data_o,
  output logic              wr_en_o,
  output logic              c_o,
  output logic              z_o
);
  logic accept;

  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      data_o      <= '0;
      wr_en_o     <= 1'b0;
      c_o         <= 1'b0;
      z_o         <= 1'b0;
    end else begin
      if (accept) begin
        out_valid_o <= 1'b1;
        data_o      <= data_i;
        wr_en_o     <= wr_en_i;
        c_o         <= c_i;
        z_o         <= z_i;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bit_op_unit.sv
module bit_op_unit
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  bit_sel_i,
  input  logic              c_i,
  input  logic              z_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] data_o,
  output logic              wr_en_o,
  output logic              c_o,
  output logic              z_o
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] data_n;
  logic              wr_en_n;
  logic              c_n;
  logic              z_n;

  bit_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .sel_i  (bit_sel_i),
    .mask_o (mask)
  );

  bit_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i    (op_i),
    .data_i  (data_i),
    .mask_i  (mask),
    .c_i     (c_i),
    .z_i     (z_i),
    .data_o  (data_n),
    .wr_en_o (wr_en_n),
    .c_o     (c_n),
    .z_o     (z_n)
  );

  bit_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .data_i      (data_n),
    .wr_en_i     (wr_en_n),
    .c_i         (c_n),
    .z_i         (z_n),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .data_o      (data_o),
    .wr_en_o     (wr_en_o),
    .c_o         (c_o),
    .z_o         (z_o)
  );
endmodule

// File: rtl/bit_op_unit_chk.sv
module bit_op_unit_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] data_i,
  input logic [IDX_W-1:0]  bit_sel_i,
  input logic              c_i,
  input logic              z_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] data_o,
  input logic              wr_en_o,
  input logic              c_o,
  input logic              z_o
);
  logic              acc;
  logic [DATA_W-1:0] one;
  assign acc = in_valid_i & in_ready_o;
  assign one = {{(DATA_W-1){1'b0}}, 1'b1};

  a_r9_accept_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o);

  a_r2_set_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == 4'd0 |=> wr_en_o && data_o == ($past(data_i) | (one << $past(bit_sel_i)))
                            && c_o == $past(c_i));

  a_r3_test_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == 4'd3 |=> !wr_en_o && data_o == $past(data_i));

  a_r6_bool_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i >= 4'd8 |=> !wr_en_o && data_o == $past(data_i) && z_o == $past(z_i));

  a_r7_z_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i != 4'd3 |=> z_o == $past(z_i));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(data_o) && $stable(wr_en_o)
                                    && $stable(c_o) && $stable(z_o));

  a_r10_stall_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);
endmodule

bind bit_op_unit bit_op_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_bit_op_unit.sv
module tb_bit_op_unit;
  localparam int DATA_W = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [3:0] op_i = '0;
  logic [7:0] data_i = '0;
  logic [2:0] bit_sel_i = '0;
  logic       c_i = 1'b0;
  logic       z_i = 1'b0;
  logic       out_valid_o;
  logic       out_ready_i = 1'b1;
  logic [7:0] data_o;
  logic       wr_en_o;
  logic       c_o;
  logic       z_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bit_op_unit #(.DATA_W(DATA_W)) dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    if (op < 3) return "R2";
    if (op == 3) return "R3";
    if (op < 6) return "R4";
    if (op < 8) return "R5";
    if (op < 14) return "R6";
    return "R8";
  endfunction

  // expected {data, wr, c, z}
  function automatic logic [10:0] model(input int op, input logic [7:0] d,
                                        input int s, input bit c, input bit z);
    logic [7:0] m = 8'(1 << s);
    bit b = ((d >> s) & 1) != 0;
    logic [7:0] rd = d;
    bit wr = 0, rc = c, rz = z;
    case (op)
      0: begin rd = d | m; wr = 1; end
      1: begin rd = d & ~m; wr = 1; end
      2: begin rd = d ^ m; wr = 1; end
      3: rz = !b;
      4: rc = b;
      5: rc = !b;
      6: begin rd = c ? (d | m) : (d & ~m); wr = 1; end
      7: begin rd = !c ? (d | m) : (d & ~m); wr = 1; end
      8: rc = c && b;
      9: rc = c && !b;
      10: rc = c || b;
      11: rc = c || !b;
      12: rc = c != b;
      13: rc = c == b;
      default: ;
    endcase
    return {rd, wr, rc, rz};
  endfunction

  task automatic run_one(input int op, input logic [7:0] d, input int s,
                         input bit c, input bit z);
    logic [10:0] e;
    string r;
    e = model(op, d, s, c, z);
    r = req_of(op);
    @(negedge clk_i);
    op_i = 4'(op); data_i = d; bit_sel_i = 3'(s); c_i = c; z_i = z;
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check(out_valid_o == 1'b1, "R9", "out_valid", 16'(out_valid_o), 16'h1);
    // R1: untouched bits kept, addressed bit as modelled
    check(data_o == e[10:3], (op < 3 || op == 6 || op == 7) ? r : "R1", "data",
          16'(data_o), 16'(e[10:3]));
    check(wr_en_o == e[2], r, "wr_en", 16'(wr_en_o), 16'(e[2]));
    check(c_o == e[1], (op < 4 || op == 6 || op == 7) ? "R7" : r, "carry",
          16'(c_o), 16'(e[1]));
    check(z_o == e[0], (op == 3) ? "R3" : "R7", "zero", 16'(z_o), 16'(e[0]));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(out_valid_o == 1'b0, "R9", "reset out_valid", 16'(out_valid_o), 16'h0);
    check(in_ready_o == 1'b1, "R9", "reset in_ready", 16'(in_ready_o), 16'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int op = 0; op < 16; op++)
      for (int s = 0; s < 8; s++)
        for (int cz = 0; cz < 4; cz++)
          for (int p = 0; p < 4; p++)
            run_one(op, pats[p], s, cz[1], cz[0]);

    // R10 stall: first result held, second request blocked
    @(negedge clk_i);
    out_ready_i = 1'b0;
    op_i = 4'd0; data_i = 8'h00; bit_sel_i = 3'd4; c_i = 1'b0; z_i = 1'b0;
    in_valid_i = 1'b1;
    @(negedge clk_i);
    op_i = 4'd1; data_i = 8'hFF; bit_sel_i = 3'd2; c_i = 1'b1; z_i = 1'b1;
    check(in_ready_o == 1'b0, "R10", "in_ready stalled", 16'(in_ready_o), 16'h0);
    repeat (2) @(negedge clk_i);
    check(out_valid_o == 1'b1, "R10", "valid held", 16'(out_valid_o), 16'h1);
    check(data_o == 8'h10, "R10", "data held", 16'(data_o), 16'h10);
    check(z_o == 1'b0, "R10", "zero held", 16'(z_o), 16'h0);
    out_ready_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check(out_valid_o == 1'b1, "R10", "drain+accept valid", 16'(out_valid_o), 16'h1);
    check(data_o == 8'hFB, "R10", "second result", 16'(data_o), 16'hFB);
    check(c_o == 1'b1 && z_o == 1'b1, "R10", "second flags",
          16'({c_o, z_o}), 16'h3);
    @(negedge clk_i);
    check(out_valid_o == 1'b0, "R10", "drained", 16'(out_valid_o), 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule